// File: doc/BRIEF.md
# System Tick Timer

This block is a periodic down-counter that gives a processor core a regular time base. Software loads a 24-bit period value, chooses whether the count advances on every processor clock or only on the cycles flagged by an external reference tick input, and starts the counter. Each time the counter passes through zero, a sticky wrap flag is set. If software has enabled it, the block also raises a one-cycle exception request towards the interrupt controller. The block then either reloads and keeps running, or stops on its own when the period value is zero.

Software reaches the block through a simple register port. A request is one cycle of `bus_valid`, carrying a write strobe, a byte offset and write data. Read data comes back one cycle later, marked by `rd_valid`.

Control is held in a three-state machine:

- `ST_IDLE`: disabled, with no retained count.
- `ST_RUN`: counting.
- `ST_HOLD`: disabled, with a retained count.

The named transitions are:

- START (`ST_IDLE` to `ST_RUN`): enabling loads the period value.
- PRELOAD (`ST_IDLE` to `ST_HOLD`): a write to the current-value register while idle loads the period value.
- PAUSE (`ST_RUN` to `ST_HOLD`): clearing the enable bit.
- RESUME (`ST_HOLD` to `ST_RUN`): enabling again continues from the held count.
- ONESHOT (`ST_RUN` to `ST_IDLE`): an expiry with a zero period value.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control, reload and current-value registers all read 0, and `exc_req` is low.
- R2: The control register sits at offset 0x10, with enable at bit 0, exception-enable at bit 1, source select at bit 2 (1 = every clock, 0 = reference ticks only) and the wrap flag at bit 16. A write changes only bits 2:0, so a write can never set bit 16. All other bits read as 0.
- R3: While enabled, the count starts from the reload value and falls by one per counting tick, and one full period spans reload+1 ticks. With bit 2 clear, the count moves only in cycles where `ref_tick` is high.
- R4: On the tick where the count is already zero, the wrap flag is set. `exc_req` is then high for exactly one cycle if bit 1 is set, and stays low if bit 1 is clear.
- R5: A read of the control register returns the flag as it stood, then clears it. An expiry in the same cycle as the read wins over the clear.
- R6: If the reload value is zero at expiry, the enable bit clears itself and counting stops.
- R7: Any write to the current-value register (offset 0x18), whatever its data, reloads the count from the reload value and clears the wrap flag.
- R8: The current-value register reads 0 whenever the enable bit is clear.
- R9: Changing bit 2 with a control write while the timer runs restarts the count from the reload value.
- R10: The calibration register (offset 0x1C) always reads 10000.
- R11: The reload register (offset 0x14) keeps write data bits 23:0. Bits 31:24 are dropped and read back as 0.
- R12: Clearing and then setting the enable bit resumes from the held count. Enabling from the idle state, where no count is retained, loads the reload value.
- R13: Every read request returns `rd_valid` high with its data in the next cycle, and in no other cycle. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register request strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| ref_tick | input | 1 | Reference-clock tick enable, used when bit 2 is clear |
| rd_valid | output | 1 | Read data is valid this cycle |
| rd_data | output | DATA_W | Read data for the request of the previous cycle |
| exc_req | output | 1 | One-cycle exception request on expiry |

## Verification
The counter is driven in four ways:

- **Every-clock source, several reload values.** Running from the every-clock source with reload values of 0, 1, 2, 5, 8 and 10 separates off-by-one errors in the period from faults in the reload path.
- **Reference-tick source.** Switching to the reference-tick source with `ref_tick` pulsed for a known number of cycles, then held low, shows whether the count follows the tick input and ignores the plain clock.
- **Pause and resume.** Pausing and resuming mid-count, then stopping after a single zero-reload expiry and re-enabling from idle, separates the retained-count path from the fresh-load path.
- **Edge writes.** Writes of all-ones and flag-bit patterns to the control and reload registers show which bits software can reach. Back-to-back control reads show the read-clear of the flag.

// File: rtl/tick_pkg.sv
package tick_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } tick_state_e;

    // Control register bit positions
    localparam int CB_EN   = 0;
    localparam int CB_IRQ  = 1;
    localparam int CB_SRC  = 2;
    localparam int CB_FLAG = 16;

    // Register byte offsets
    localparam logic [7:0] OFS_CTRL   = 8'h10;
    localparam logic [7:0] OFS_RELOAD = 8'h14;
    localparam logic [7:0] OFS_CUR    = 8'h18;
    localparam logic [7:0] OFS_CAL    = 8'h1C;

endpackage

// File: rtl/tick_cfg_regs.sv
module tick_cfg_regs #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic             wr_reload,
    input  logic             wr_cur,
    input  logic             rd_ctrl,
    input  logic [2:0]       ctrl_bits,
    input  logic [CNT_W-1:0] reload_in,
    input  logic             expire,
    output logic             irq_en,
    output logic             src_sel,
    output logic [CNT_W-1:0] reload_q,
    output logic             flag_q,
    output logic             exc_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en   <= 1'b0;
            src_sel  <= 1'b0;
            reload_q <= '0;
        end else begin
            if (wr_ctrl) begin
                irq_en  <= ctrl_bits[1];
                src_sel <= ctrl_bits[2];
            end
            if (wr_reload) begin
                reload_q <= reload_in;
            end
        end
    end

    // Sticky wrap flag: an expiry outranks the clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (expire) begin
            flag_q <= 1'b1;
        end else if (rd_ctrl || wr_cur) begin
            flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_q <= 1'b0;
        end else begin
            exc_q <= expire && irq_en;
        end
    end

endmodule

// File: rtl/tick_count_fsm.sv
module tick_count_fsm
    import tick_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_ctrl,
    input  logic             cmd_en,
    input  logic             cmd_src,
    input  logic             cmd_cur,
    input  logic             src_sel,
    input  logic             ref_tick,
    input  logic [CNT_W-1:0] reload,
    output logic             run_en,
    output logic [CNT_W-1:0] cur_cnt,
    output logic             expire,
    output logic             tick
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    tick_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    assign tick    = src_sel || ref_tick;
    assign run_en  = (state_q == ST_RUN);
    assign cur_cnt = cnt_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Next state, next count and the expiry strobe
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        expire  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_ctrl && cmd_en) begin          // START
                    state_d = ST_RUN;
                    cnt_d   = reload;
                end else if (cmd_cur) begin            // PRELOAD
                    state_d = ST_HOLD;
                    cnt_d   = reload;
                end
            end
            ST_HOLD: begin
                if (cmd_ctrl && cmd_en) begin          // RESUME
                    state_d = ST_RUN;
                end else if (cmd_cur) begin
                    cnt_d = reload;
                end
            end
            ST_RUN: begin
                if (cmd_ctrl && !cmd_en) begin         // PAUSE
                    state_d = ST_HOLD;
                end else if (cmd_cur) begin
                    cnt_d = reload;
                end else if (cmd_ctrl && (cmd_src != src_sel)) begin
                    cnt_d = reload;
                end else if (tick) begin
                    if (cnt_q == '0) begin
                        expire = 1'b1;
                        if (reload == '0) begin        // ONESHOT
                            state_d = ST_IDLE;
                        end else begin
                            cnt_d = reload;
                        end
                    end else begin
                        cnt_d = cnt_q - CNT_ONE;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/tick_read_port.sv
module tick_read_port
    import tick_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 24,
    parameter int CAL_VALUE = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              run_en,
    input  logic              irq_en,
    input  logic              src_sel,
    input  logic              flag,
    input  logic [CNT_W-1:0]  reload,
    input  logic [CNT_W-1:0]  cur_cnt,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        if (addr == ADDR_W'(OFS_CTRL)) begin
            rd_mux[CB_EN]   = run_en;
            rd_mux[CB_IRQ]  = irq_en;
            rd_mux[CB_SRC]  = src_sel;
            rd_mux[CB_FLAG] = flag;
        end else if (addr == ADDR_W'(OFS_RELOAD)) begin
            rd_mux = DATA_W'(reload);
        end else if (addr == ADDR_W'(OFS_CUR)) begin
            rd_mux = run_en ? DATA_W'(cur_cnt) : '0;
        end else if (addr == ADDR_W'(OFS_CAL)) begin
            rd_mux = DATA_W'(CAL_VALUE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) begin
                rd_data <= rd_mux;
            end
        end
    end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 24,
    parameter int CAL_VALUE = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              ref_tick,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              exc_req
);

    logic             sel_ctrl, sel_reload, sel_cur;
    logic             wr_ctrl, wr_reload, wr_cur, wr_any, rd_ctrl, rd_req;
    logic             irq_en, src_sel, flag, run_en, expire, tick;
    logic [CNT_W-1:0] reload, cur_cnt;
    logic             unused_wdata_hi;

    assign sel_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
    assign sel_reload = (bus_addr == ADDR_W'(OFS_RELOAD));
    assign sel_cur    = (bus_addr == ADDR_W'(OFS_CUR));

    assign wr_any    = bus_valid && bus_write;
    assign wr_ctrl   = wr_any && sel_ctrl;
    assign wr_reload = wr_any && sel_reload;
    assign wr_cur    = wr_any && sel_cur;
    assign rd_req    = bus_valid && !bus_write;
    assign rd_ctrl   = rd_req && sel_ctrl;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

    tick_cfg_regs #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wr_reload (wr_reload),
        .wr_cur    (wr_cur),
        .rd_ctrl   (rd_ctrl),
        .ctrl_bits (bus_wdata[2:0]),
        .reload_in (bus_wdata[CNT_W-1:0]),
        .expire    (expire),
        .irq_en    (irq_en),
        .src_sel   (src_sel),
        .reload_q  (reload),
        .flag_q    (flag),
        .exc_q     (exc_req)
    );

    tick_count_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_ctrl (wr_ctrl),
        .cmd_en   (bus_wdata[CB_EN]),
        .cmd_src  (bus_wdata[CB_SRC]),
        .cmd_cur  (wr_cur),
        .src_sel  (src_sel),
        .ref_tick (ref_tick),
        .reload   (reload),
        .run_en   (run_en),
        .cur_cnt  (cur_cnt),
        .expire   (expire),
        .tick     (tick)
    );

    tick_read_port #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W),
        .CAL_VALUE (CAL_VALUE)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .addr     (bus_addr),
        .run_en   (run_en),
        .irq_en   (irq_en),
        .src_sel  (src_sel),
        .flag     (flag),
        .reload   (reload),
        .cur_cnt  (cur_cnt),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
    import tick_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 24,
    parameter int CAL_VALUE = 10000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              exc_req,
    input logic              run_en,
    input logic [CNT_W-1:0]  cur_cnt,
    input logic [CNT_W-1:0]  reload,
    input logic              expire,
    input logic              flag,
    input logic              rd_ctrl,
    input logic              wr_any
);

    assert_exc_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> !exc_req);

    assert_exc_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exc_req) |-> $past(expire));

    assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag);

    assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctrl && !expire) |=> !flag);

    assert_oneshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && (reload == '0)) |=> !run_en);

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr_any) |=> $stable(cur_cnt));

    assert_rd_latency_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> rd_valid);

    assert_rd_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> !rd_valid);

    assert_cal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && (bus_addr == ADDR_W'(OFS_CAL)))
        |=> (rd_data == DATA_W'(CAL_VALUE)));

    assert_reload_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && (bus_addr == ADDR_W'(OFS_RELOAD)))
        |=> (rd_data[DATA_W-1:CNT_W] == '0));

    assert_cur_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && (bus_addr == ADDR_W'(OFS_CUR)) && !run_en)
        |=> (rd_data == '0));

endmodule

bind tick_timer tick_timer_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W),
    .CAL_VALUE (CAL_VALUE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .exc_req   (exc_req),
    .run_en    (run_en),
    .cur_cnt   (cur_cnt),
    .reload    (reload),
    .expire    (expire),
    .flag      (flag),
    .rd_ctrl   (rd_ctrl),
    .wr_any    (wr_any)
);

// File: tb/sim_tick_timer.sv
module sim_tick_timer;

    localparam logic [7:0] A_CTRL = 8'h10;
    localparam logic [7:0] A_RLD  = 8'h14;
    localparam logic [7:0] A_CUR  = 8'h18;
    localparam logic [7:0] A_CAL  = 8'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        ref_tick = 1'b0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        exc_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    tick_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ref_tick  (ref_tick),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .exc_req   (exc_req)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    // Driver: queues the expected reply, the monitor compares it
    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_noexc(input int n, input string tag);
        int highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (exc_req) highs++;
        end
        check(highs == 0, tag, highs, 0);
    endtask

    // Monitor
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R13 unexpected rd_valid", 32'd1, 32'd0);
            end else begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_data === e, t, rd_data, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog expired", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int first;
        int highs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(exc_req == 1'b0, "R1 exc_req after reset", exc_req, 0);
        rd(A_CTRL, 32'h0, "R1 ctrl reset");
        rd(A_RLD,  32'h0, "R1 reload reset");
        rd(A_CUR,  32'h0, "R1 current reset");

        // R11, R10, R13, R2
        wr(A_RLD, 32'hFF12_3456);
        rd(A_RLD, 32'h0012_3456, "R11 reload upper bits dropped");
        rd(A_CAL, 32'd10000, "R10 calibration");
        rd(8'h20, 32'h0, "R13 unmapped offset");
        idle(2);
        check(rd_valid == 1'b0, "R13 rd_valid low when idle", rd_valid, 0);
        wr(A_CTRL, 32'h0001_0006);
        rd(A_CTRL, 32'h0000_0006, "R2 flag not writable");
        wr(A_CTRL, 32'hFFFF_FFF8);
        rd(A_CTRL, 32'h0, "R2 only bits 2:0 written");

        // R3 / R8 / R12: reload 5, pause, resume
        wr(A_RLD, 32'd5);
        wr(A_CUR, 32'h0);
        wr(A_CTRL, 32'h5);
        rd(A_CUR, 32'd5, "R3 count starts at reload");
        rd(A_CUR, 32'd4, "R3 count step 1");
        rd(A_CUR, 32'd3, "R3 count step 2");
        wr(A_CTRL, 32'h4);
        rd(A_CUR, 32'h0, "R8 current reads 0 when disabled");
        rd(A_CTRL, 32'h4, "R8 ctrl after pause");
        idle(3);
        wr(A_CTRL, 32'h5);
        rd(A_CUR, 32'd2, "R12 resume from held count");
        idle_noexc(6, "R4 no exc_req with bit1 clear");
        wr(A_CTRL, 32'h4);
        rd(A_CTRL, 32'h0001_0004, "R4 flag set on expiry");
        rd(A_CTRL, 32'h0000_0004, "R5 flag cleared by read");

        // R4 / R3: exception pulses, reload 2 -> period 3
        wr(A_RLD, 32'd2);
        wr(A_CUR, 32'h0);
        wr(A_CTRL, 32'h7);
        first = -1;
        highs = 0;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            if (exc_req) begin
                highs++;
                if (first < 0) first = i;
            end
        end
        check(first == 3, "R3 first expiry after reload+1 ticks", first, 3);
        check(highs == 2, "R4 one-cycle exc_req per period", highs, 2);
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, 32'h0001_0000, "R5 read returns flag");
        rd(A_CTRL, 32'h0, "R5 second read sees flag cleared");

        // R6 one-shot, then R12 fresh load from idle
        wr(A_RLD, 32'd0);
        wr(A_CUR, 32'h0);
        wr(A_CTRL, 32'h5);
        idle_noexc(2, "R6 no exc_req in one-shot with bit1 clear");
        rd(A_CTRL, 32'h0001_0004, "R6 enable cleared after one-shot");
        rd(A_CUR, 32'h0, "R6 current reads 0 after stop");
        wr(A_RLD, 32'd3);
        wr(A_CTRL, 32'h5);
        rd(A_CUR, 32'd3, "R12 fresh load from idle");
        wr(A_CTRL, 32'h4);

        // R7 current write reloads and clears flag
        wr(A_RLD, 32'd10);
        wr(A_CUR, 32'h0);
        wr(A_CTRL, 32'h5);
        idle(4);
        wr(A_CUR, 32'h0000_0123);
        rd(A_CUR, 32'd10, "R7 current write reloads");
        wr(A_CTRL, 32'h4);
        wr(A_RLD, 32'd1);
        wr(A_CUR, 32'h0);
        wr(A_CTRL, 32'h5);
        idle(3);
        wr(A_CUR, 32'hDEAD_BEEF);
        rd(A_CTRL, 32'h5, "R7 current write clears flag");
        wr(A_CTRL, 32'h4);

        // R9 source change restarts, R3 reference ticks
        wr(A_RLD, 32'd8);
        wr(A_CUR, 32'h0);
        wr(A_CTRL, 32'h5);
        idle(3);
        wr(A_CTRL, 32'h1);
        rd(A_CUR, 32'd8, "R9 source change restarts count");
        ref_tick = 1'b1;
        idle(3);
        ref_tick = 1'b0;
        rd(A_CUR, 32'd5, "R3 counts reference ticks");
        idle(5);
        rd(A_CUR, 32'd5, "R3 no count without reference ticks");
        wr(A_CTRL, 32'h0);

        idle(3);
        check(exp_q.size() == 0, "R13 all reads answered", exp_q.size(), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule